// File: doc/BRIEF.md
# Sv39 Hardware Page-Table Walker with 64 KiB Contiguous Leaves

This block turns a 39-bit virtual address into a 56-bit physical address by walking a three-level radix page table held in memory. A requester hands it one translation at a time: the virtual address, whether the access is a store, whether the requester runs in supervisor or user mode, and the supervisor-may-touch-user-pages permission bit. The walker reads one 64-bit entry per level through a single-outstanding memory port. It then returns either a physical address with the leaf's attribute bits or a page fault, as a one-cycle response pulse.

Leaves sit at the lowest level only. A lowest-level leaf can also describe a naturally aligned 64 KiB region: its top bit (N) is set and the low four bits of its physical page number read 4'b1000. For such a leaf, physical address bits 15:12 come from the virtual address and not from the entry. The translation mode and root table page number come in as side-band inputs. When the mode code is not the Sv39 code (8), the walker does not touch memory and passes the address through.

Top module: `sv39_walker`

## Requirements
- R1: After reset `req_ready`=1, `rsp_valid`=0 and `mem_req_valid`=0. A request is taken when `req_valid` and `req_ready` are both high, and `req_ready` stays low until that request's response has been given.
- R2: When `satp_mode` is not 8, no memory read is made. The response has `rsp_fault`=0, `rsp_paddr` equal to the virtual address zero-extended, and `rsp_flags`=0.
- R3: In Sv39 mode the first read is at root_ppn*4096 + VA[38:30]*8. The following reads are at next_ppn*4096 + VA[29:21]*8 and then + VA[20:12]*8. There is one read per level, the address is held until `mem_req_ready`, and the next read starts only after `mem_rsp_valid`.
- R4: An entry with V (bit 0)=1 and R, W, X (bits 1, 2, 3) all 0 is a pointer, and the walk continues at its PPN (bits 53:10). A pointer met at the lowest level is a fault.
- R5: An entry with V=0, with W=1 and R=0, or with any of bits 62:54 set is a fault, and the walk stops at that read.
- R6: A leaf found at the top or middle level is a fault.
- R7: A lowest-level leaf with N (bit 63)=0 yields paddr = {PPN, VA[11:0]} and `rsp_flags` = entry bits 9:0.
- R8: A lowest-level leaf with N=1 and PPN[3:0]=4'b1000 yields paddr = {PPN[43:4], VA[15:12], VA[11:0]}.
- R9: N=1 on a pointer, or N=1 on a leaf whose PPN[3:0] is not 4'b1000, is a fault.
- R10: A leaf with A (bit 6)=0 is a fault. A store also needs W=1 and D (bit 7)=1. A load needs R=1.
- R11: A leaf with U (bit 4)=1 is a fault for a supervisor access unless `req_sum`=1. A leaf with U=0 is a fault for a user access.
- R12: `rsp_valid` is high for exactly one cycle per request. On a fault `rsp_paddr`=0 and `rsp_flags`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_vaddr | input | 39 | Virtual address |
| req_store | input | 1 | 1 = store, 0 = load |
| req_smode | input | 1 | 1 = supervisor access, 0 = user access |
| req_sum | input | 1 | Supervisor may access user pages |
| satp_mode | input | 4 | Translation mode code, 8 selects Sv39 |
| satp_root_ppn | input | 44 | Page number of the root table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 56 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Entry contents |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_fault | output | 1 | Page fault |
| rsp_paddr | output | 56 | Physical address |
| rsp_flags | output | 10 | Leaf attribute bits 9:0 |

## Verification
The sharpest case is the contiguous 64 KiB leaf, which the bench reaches from virtual addresses whose bits 15:12 are nonzero. A walker that copies the entry's low PPN bits would land in the wrong 4 KiB page, for example 0x90018010 instead of 0x90011010. The bench also feeds entries with N set and a wrong low pattern, N set on a pointer, and leaves at upper levels. A walker that skipped those checks would hand back an address where a fault is due. It counts and compares every entry address against a behavioural walk, which exposes a wrong level index or a walk that runs on after a faulting level. Memory latency varies between runs to show that the address is held and that the walker waits for read data.

// File: rtl/sv39w_pkg.sv
`timescale 1ns/1ps
package sv39w_pkg;
    localparam int VA_W     = 39;
    localparam int PA_W     = 56;
    localparam int PPN_W    = 44;
    localparam int OFF_W    = 12;
    localparam int VPN_W    = 9;
    localparam int LEVELS   = 3;
    localparam int PTE_W    = 64;
    localparam int LVL_W    = $clog2(LEVELS);
    localparam int ATTR_W   = 10;
    localparam int NAPOT_BITS = 4;
    localparam int ENTRY_SHIFT = 3;
    localparam logic [3:0] MODE_SV39 = 4'd8;
    localparam logic [NAPOT_BITS-1:0] NAPOT_TAG = 4'b1000;

    typedef struct packed {
        logic             n;
        logic [8:0]       rsvd;
        logic [PPN_W-1:0] ppn;
        logic [1:0]       rsw;
        logic             d;
        logic             a;
        logic             g;
        logic             u;
        logic             x;
        logic             w;
        logic             r;
        logic             v;
    } pte_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MREQ,
        ST_MWAIT,
        ST_RESP
    } walk_state_e;

    typedef struct packed {
        logic              fault;
        logic              descend;
        logic [PPN_W-1:0]  next_ppn;
        logic [PA_W-1:0]   paddr;
        logic [ATTR_W-1:0] flags;
    } verdict_t;

    function automatic logic [VPN_W-1:0] vpn_of(input logic [VA_W-1:0] va,
                                               input logic [LVL_W-1:0] lvl);
        logic [VPN_W-1:0] s;
        s = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (lvl == LVL_W'(i)) s = va[OFF_W + i*VPN_W +: VPN_W];
        end
        return s;
    endfunction
endpackage

// File: rtl/sv39w_entry_addr.sv
`timescale 1ns/1ps
module sv39w_entry_addr
    import sv39w_pkg::*;
(
    input  logic [PPN_W-1:0] base_ppn,
    input  logic [VA_W-1:0]  vaddr,
    input  logic [LVL_W-1:0] level,
    output logic [PA_W-1:0]  entry_addr
);
    localparam int IDX_PAD = PA_W - VPN_W - ENTRY_SHIFT;

    logic [VPN_W-1:0] idx;

    always_comb begin
        idx        = vpn_of(vaddr, level);
        entry_addr = {base_ppn, {OFF_W{1'b0}}}
                   + {{IDX_PAD{1'b0}}, idx, {ENTRY_SHIFT{1'b0}}};
    end
endmodule

// File: rtl/sv39w_pte_eval.sv
`timescale 1ns/1ps
module sv39w_pte_eval
    import sv39w_pkg::*;
(
    input  logic [PTE_W-1:0] pte_raw,
    input  logic [LVL_W-1:0] level,
    input  logic [VA_W-1:0]  vaddr,
    input  logic             is_store,
    input  logic             smode,
    input  logic             sum,
    output verdict_t         verdict
);
    pte_t p;
    logic leaf;
    logic napot;
    logic bad;
    logic [PA_W-1:0] pa_plain;
    logic [PA_W-1:0] pa_napot;

    always_comb begin
        p     = pte_t'(pte_raw);
        leaf  = p.r | p.w | p.x;
        napot = p.n && (p.ppn[NAPOT_BITS-1:0] == NAPOT_TAG);
        bad   = !p.v || (p.w && !p.r) || (p.rsvd != '0);
        if (!leaf) begin
            bad = bad || p.n || (level == '0);
        end else begin
            bad = bad || (level != '0) || (p.n && !napot) || !p.a;
            bad = bad || (is_store ? (!p.w || !p.d) : !p.r);
            bad = bad || (p.u ? (smode && !sum) : !smode);
        end

        pa_plain = {p.ppn, vaddr[OFF_W-1:0]};
        pa_napot = {p.ppn[PPN_W-1:NAPOT_BITS],
                    vaddr[OFF_W +: NAPOT_BITS], vaddr[OFF_W-1:0]};

        verdict.fault    = bad;
        verdict.descend  = !bad && !leaf;
        verdict.next_ppn = p.ppn;
        verdict.paddr    = bad ? '0 : (napot ? pa_napot : pa_plain);
        verdict.flags    = bad ? '0 : pte_raw[ATTR_W-1:0];
    end
endmodule

// File: rtl/sv39_walker.sv
`timescale 1ns/1ps
module sv39_walker
    import sv39w_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_store,
    input  logic              req_smode,
    input  logic              req_sum,
    input  logic [3:0]        satp_mode,
    input  logic [PPN_W-1:0]  satp_root_ppn,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [ATTR_W-1:0] rsp_flags
);
    localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LEVELS - 1);

    walk_state_e       state_q;
    logic [LVL_W-1:0]  level_q;
    logic [PPN_W-1:0]  base_q;
    logic [VA_W-1:0]   va_q;
    logic              store_q;
    logic              smode_q;
    logic              sum_q;
    logic              fault_q;
    logic [PA_W-1:0]   paddr_q;
    logic [ATTR_W-1:0] flags_q;
    verdict_t          verdict;

    sv39w_entry_addr u_addr (
        .base_ppn   (base_q),
        .vaddr      (va_q),
        .level      (level_q),
        .entry_addr (mem_req_addr)
    );

    sv39w_pte_eval u_eval (
        .pte_raw  (mem_rsp_data),
        .level    (level_q),
        .vaddr    (va_q),
        .is_store (store_q),
        .smode    (smode_q),
        .sum      (sum_q),
        .verdict  (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            level_q <= '0;
            base_q  <= '0;
            va_q    <= '0;
            store_q <= 1'b0;
            smode_q <= 1'b0;
            sum_q   <= 1'b0;
            fault_q <= 1'b0;
            paddr_q <= '0;
            flags_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q    <= req_vaddr;
                        store_q <= req_store;
                        smode_q <= req_smode;
                        sum_q   <= req_sum;
                        if (satp_mode == MODE_SV39) begin
                            level_q <= TOP_LVL;
                            base_q  <= satp_root_ppn;
                            state_q <= ST_MREQ;
                        end else begin
                            fault_q <= 1'b0;
                            paddr_q <= {{(PA_W-VA_W){1'b0}}, req_vaddr};
                            flags_q <= '0;
                            state_q <= ST_RESP;
                        end
                    end
                end
                ST_MREQ: begin
                    if (mem_req_ready) state_q <= ST_MWAIT;
                end
                ST_MWAIT: begin
                    if (mem_rsp_valid) begin
                        if (verdict.descend) begin
                            base_q  <= verdict.next_ppn;
                            level_q <= level_q - 1'b1;
                            state_q <= ST_MREQ;
                        end else begin
                            fault_q <= verdict.fault;
                            paddr_q <= verdict.paddr;
                            flags_q <= verdict.flags;
                            state_q <= ST_RESP;
                        end
                    end
                end
                ST_RESP: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready     = (state_q == ST_IDLE);
    assign mem_req_valid = (state_q == ST_MREQ);
    assign rsp_valid     = (state_q == ST_RESP);
    assign rsp_fault     = fault_q;
    assign rsp_paddr     = paddr_q;
    assign rsp_flags     = flags_q;
endmodule

// File: rtl/sv39_walker_chk.sv
`timescale 1ns/1ps
module sv39_walker_chk
    import sv39w_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [PA_W-1:0]   mem_req_addr,
    input logic              rsp_valid,
    input logic              rsp_fault,
    input logic [PA_W-1:0]   rsp_paddr,
    input logic [ATTR_W-1:0] rsp_flags
);
    a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    a_r1_no_accept_while_reading: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !req_ready);

    a_r3_hold_read: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    a_r3_entry_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (mem_req_addr[ENTRY_SHIFT-1:0] == '0));

    a_r12_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    a_r12_fault_clean: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && rsp_flags == '0));
endmodule

bind sv39_walker sv39_walker_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .rsp_paddr     (rsp_paddr),
    .rsp_flags     (rsp_flags)
);

// File: tb/tb_sv39_walker.sv
`timescale 1ns/1ps
module tb_sv39_walker;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [38:0] req_vaddr;
    logic        req_store;
    logic        req_smode;
    logic        req_sum;
    logic [3:0]  satp_mode;
    logic [43:0] satp_root_ppn;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [55:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [55:0] rsp_paddr;
    logic [9:0]  rsp_flags;

    localparam logic [43:0] ROOT = 44'h80000;

    int checks = 0;
    int failures = 0;
    int lat = 0;
    logic [63:0] mem [logic [55:0]];
    logic [55:0] act_addrs[$];
    logic [55:0] exp_addrs[$];
    logic [55:0] cur_addr;

    always #4 clk = ~clk;

    sv39_walker dut (.*);

    function automatic logic [63:0] rd(input logic [55:0] a);
        if (mem.exists(a)) return mem[a];
        return 64'd0;
    endfunction

    function automatic logic [63:0] mk_pte(input logic [43:0] ppn, input logic [7:0] fl, input bit n);
        return {n, 9'd0, ppn, 2'b00, fl};
    endfunction

    function automatic logic [38:0] mkva(input int v2, input int v1, input int v0, input int off);
        return {v2[8:0], v1[8:0], v0[8:0], off[11:0]};
    endfunction

    function automatic logic [43:0] l1_ppn(input logic [38:0] va);
        return 44'h81000 + {35'd0, va[38:30]} * 2;
    endfunction

    function automatic logic [55:0] l2_slot(input logic [38:0] va);
        return {ROOT, 12'd0} + va[38:30] * 8;
    endfunction
    function automatic logic [55:0] l1_slot(input logic [38:0] va);
        return {l1_ppn(va), 12'd0} + va[29:21] * 8;
    endfunction
    function automatic logic [55:0] l0_slot(input logic [38:0] va);
        return {l1_ppn(va) + 44'd1, 12'd0} + va[20:12] * 8;
    endfunction

    task automatic map(input logic [38:0] va, input logic [63:0] leaf);
        mem[l2_slot(va)] = mk_pte(l1_ppn(va), 8'h01, 1'b0);
        mem[l1_slot(va)] = mk_pte(l1_ppn(va) + 44'd1, 8'h01, 1'b0);
        mem[l0_slot(va)] = leaf;
    endtask

    task automatic ref_walk(input logic [38:0] va, input bit st, input bit sm, input bit su,
                            input logic [3:0] md, output bit f, output logic [55:0] pa,
                            output logic [9:0] fl);
        logic [43:0] base;
        logic [63:0] e;
        logic [55:0] a;
        bit bad;
        bit done;
        f = 1'b1; pa = '0; fl = '0;
        exp_addrs.delete();
        if (md != 4'd8) begin
            f = 1'b0; pa = {17'd0, va}; return;
        end
        base = ROOT;
        done = 1'b0;
        for (int lvl = 2; lvl >= 0 && !done; lvl--) begin
            a = {base, 12'd0} + ((va >> (12 + 9*lvl)) & 39'h1FF) * 8;
            exp_addrs.push_back(a);
            e = rd(a);
            bad = (e[0] == 0) || (e[2] && !e[1]) || (e[62:54] != 0);
            if (bad) begin done = 1'b1; end
            else if (e[3:1] == 3'b000) begin
                if (e[63] || lvl == 0) done = 1'b1;
                else base = e[53:10];
            end else begin
                done = 1'b1;
                bad = (lvl != 0) || (e[63] && e[13:10] != 4'b1000) || !e[6];
                if (st) bad = bad || !e[2] || !e[7];
                else    bad = bad || !e[1];
                if (e[4]) bad = bad || (sm && !su);
                else      bad = bad || !sm;
                if (!bad) begin
                    f = 1'b0;
                    fl = e[9:0];
                    pa = e[63] ? {e[53:14], va[15:0]} : {e[53:10], va[11:0]};
                end
            end
        end
    endtask

    task automatic check(input string tag, input bit ok, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic run(input string tag, input logic [38:0] va, input bit st, input bit sm,
                       input bit su, input logic [3:0] md);
        bit ef;
        logic [55:0] ep;
        logic [9:0] efl;
        int w;
        ref_walk(va, st, sm, su, md, ef, ep, efl);
        act_addrs.delete();
        @(negedge clk);
        check("R1", req_ready === 1'b1, "idle ready", {63'd0, req_ready}, 64'd1);
        req_valid = 1'b1; req_vaddr = va; req_store = st; req_smode = sm;
        req_sum = su; satp_mode = md;
        @(negedge clk);
        req_valid = 1'b0;
        w = 0;
        while (rsp_valid !== 1'b1 && w < 500) begin @(negedge clk); w++; end
        if (w >= 500) begin
            check(tag, 1'b0, "response timeout", 64'd0, 64'd1);
            return;
        end
        check(tag, rsp_fault === ef, "fault", {63'd0, rsp_fault}, {63'd0, ef});
        check(tag, rsp_paddr === ep, "paddr", {8'd0, rsp_paddr}, {8'd0, ep});
        check(tag, rsp_flags === efl, "flags", {54'd0, rsp_flags}, {54'd0, efl});
        check("R3", act_addrs.size() == exp_addrs.size(), "read count",
              64'(act_addrs.size()), 64'(exp_addrs.size()));
        for (int i = 0; i < exp_addrs.size() && i < act_addrs.size(); i++)
            check("R3", act_addrs[i] === exp_addrs[i], "read addr",
                  {8'd0, act_addrs[i]}, {8'd0, exp_addrs[i]});
        @(negedge clk);
        check("R12", rsp_valid === 1'b0 && req_ready === 1'b1, "pulse ends",
              {62'd0, rsp_valid, req_ready}, 64'd1);
        lat = (lat + 1) % 4;
    endtask

    // memory responder: accepts a read, waits lat cycles, returns entry
    initial begin
        mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        forever begin
            @(negedge clk);
            if (mem_req_valid === 1'b1 && rst === 1'b0) begin
                cur_addr = mem_req_addr;
                act_addrs.push_back(cur_addr);
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                repeat (lat) @(negedge clk);
                mem_rsp_data = rd(cur_addr);
                mem_rsp_valid = 1'b1;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        check("WDOG", 1'b0, "watchdog expired", 64'd0, 64'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [38:0] va;
        rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; req_store = 1'b0;
        req_smode = 1'b0; req_sum = 1'b0; satp_mode = 4'd8; satp_root_ppn = ROOT;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", req_ready === 1'b1 && rsp_valid === 1'b0 && mem_req_valid === 1'b0,
              "reset state", {61'd0, req_ready, rsp_valid, mem_req_valid}, 64'h4);

        // R2 bare mode passthrough
        run("R2", 39'h40201010, 1'b0, 1'b1, 1'b0, 4'd0);

        // R7 plain 4 KiB leaf, user load
        va = mkva(2, 5, 7, 12'h678);
        map(va, mk_pte(44'h12345, 8'h53, 1'b0));
        run("R7", va, 1'b0, 1'b0, 1'b0, 4'd8);

        // R8 contiguous 64 KiB leaf, S-mode store with SUM (R11)
        va = 39'h40201010;
        map(va, mk_pte(44'h90018, 8'hDF, 1'b1));
        run("R8", va, 1'b1, 1'b1, 1'b1, 4'd8);
        va = 39'h4020F2A4;
        map(va, mk_pte(44'h90018, 8'hDF, 1'b1));
        run("R8", va, 1'b0, 1'b1, 1'b1, 4'd8);
        va = mkva(3, 4, 9, 12'hABC);
        map(va, mk_pte(44'hABC08, 8'hD7, 1'b1));
        run("R8", va, 1'b1, 1'b1, 1'b0, 4'd8);

        // R9 N with wrong low pattern, N on pointer
        va = mkva(4, 1, 2, 12'h010);
        map(va, mk_pte(44'h90019, 8'hDF, 1'b1));
        run("R9", va, 1'b0, 1'b1, 1'b1, 4'd8);
        va = mkva(5, 1, 2, 12'h010);
        map(va, mk_pte(44'h55555, 8'hDF, 1'b0));
        mem[l1_slot(va)] = mk_pte(l1_ppn(va) + 44'd1, 8'h01, 1'b1);
        run("R9", va, 1'b0, 1'b1, 1'b1, 4'd8);

        // R5 invalid top entry, W without R, reserved bits
        run("R5", mkva(200, 3, 3, 0), 1'b0, 1'b1, 1'b1, 4'd8);
        va = mkva(6, 2, 2, 12'h444);
        map(va, mk_pte(44'h22222, 8'hD5, 1'b0));
        run("R5", va, 1'b1, 1'b0, 1'b0, 4'd8);
        va = mkva(7, 2, 2, 12'h444);
        map(va, mk_pte(44'h22222, 8'hD3, 1'b0) | 64'h0040_0000_0000_0000);
        run("R5", va, 1'b0, 1'b0, 1'b0, 4'd8);

        // R4 pointer at lowest level
        va = mkva(8, 3, 3, 12'h0);
        map(va, mk_pte(44'h33333, 8'h01, 1'b0));
        run("R4", va, 1'b0, 1'b1, 1'b0, 4'd8);

        // R6 leaf at middle level and at top level
        va = mkva(9, 3, 3, 12'h0);
        map(va, mk_pte(44'h33333, 8'hDF, 1'b0));
        mem[l1_slot(va)] = mk_pte(44'h44400, 8'hDF, 1'b0);
        run("R6", va, 1'b0, 1'b1, 1'b1, 4'd8);
        va = mkva(10, 3, 3, 12'h0);
        mem[l2_slot(va)] = mk_pte(44'h40000, 8'hDF, 1'b0);
        run("R6", va, 1'b0, 1'b1, 1'b1, 4'd8);

        // R10 accessed, dirty, write and read permission
        va = mkva(11, 1, 1, 12'h1);
        map(va, mk_pte(44'h11111, 8'h93, 1'b0));
        run("R10", va, 1'b0, 1'b0, 1'b0, 4'd8);
        va = mkva(12, 1, 1, 12'h1);
        map(va, mk_pte(44'h11111, 8'h57, 1'b0));
        run("R10", va, 1'b1, 1'b0, 1'b0, 4'd8);
        run("R10", va, 1'b0, 1'b0, 1'b0, 4'd8);
        va = mkva(13, 1, 1, 12'h1);
        map(va, mk_pte(44'h11111, 8'hD3, 1'b0));
        run("R10", va, 1'b1, 1'b0, 1'b0, 4'd8);
        va = mkva(14, 1, 1, 12'h1);
        map(va, mk_pte(44'h11111, 8'hD9, 1'b0));
        run("R10", va, 1'b0, 1'b0, 1'b0, 4'd8);

        // R11 privilege checks
        va = mkva(15, 6, 6, 12'h600);
        map(va, mk_pte(44'h66666, 8'h53, 1'b0));
        run("R11", va, 1'b0, 1'b1, 1'b0, 4'd8);
        run("R11", va, 1'b0, 1'b1, 1'b1, 4'd8);
        va = mkva(16, 6, 6, 12'h600);
        map(va, mk_pte(44'h66666, 8'h43, 1'b0));
        run("R11", va, 1'b0, 1'b0, 1'b0, 4'd8);
        run("R11", va, 1'b0, 1'b1, 1'b0, 4'd8);

        // R2 again with non-Sv39 code after walks
        run("R2", 39'h7F_FFFF_FFFF, 1'b1, 1'b0, 1'b0, 4'd9);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule